// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital sequencer of a successive-approximation converter. On each rising clock edge it looks at a start level. Once it sees start high, it runs a frame of fixed length. The first cycle samples the analog input. Each following cycle tries one bit of a trial code on the DAC and reads the comparator to decide that bit. At the end of the frame it raises a done flag, and the result stays on a parallel bus until the next conversion starts. While the frame runs, each decided bit is also sent out on a serial pin, most significant bit first, one cycle after it is decided.

The analog parts (sample-and-hold, DAC, comparator) sit outside this block. It drives a DAC trial code and a hold-enable signal, and it takes in one comparator bit. The block also latches three controls, each at its own point in the frame:
- the channel select is taken on the start edge;
- the single-ended/differential mode is taken from the cycle before the start edge;
- the resolution select is sampled only while done is high.

If start is held high, frames follow one another with no idle cycle between them.

Top module: `sar_conv_ctrl`

## Requirements
- R1: A frame begins only on a rising edge where `start_i` is high and the block is idle or in the last cycle of a frame. While idle with `start_i` low, no frame starts, `done_o` keeps its value and `data_o` is unchanged.
- R2: If `start_i` stays high, the next frame begins on the edge that ends the 14th cycle of the current frame. `done_o` is then high for exactly one cycle between the two frames.
- R3: A frame lasts 14 cycles. Cycle 1 is the cycle after the start edge. `done_o` is low during cycles 1 to 13 and high in cycle 14.
- R4: `done_o` goes low on the edge that starts the next frame. With no new start, it stays high for any length of time. Reset (active-low `rst_ni`) clears `done_o`, `hold_o`, `ser_o` and `data_o`, and leaves the block idle.
- R5: Cycles 2 to 13 decide bits 11 down to 0. A bit is kept as 1 if `cmp_i` is high (the input is at or above the DAC level). The 12-bit result is the input code.
- R6: `ser_o` shows each decided bit in the cycle after it is decided. Bit 11 appears in cycle 3 and bit 0 in cycle 14.
- R7: `chan_o` takes the value of `chan_sel_i` on the start edge and holds it for the whole frame.
- R8: `diff_o` takes the value `diff_mode_i` had in the cycle before the start edge. A change during the cycle just before the start edge is ignored.
- R9: `res_sel_i` is sampled only on edges where `done_o` is high, and the sampled value applies to the following frames. When 1 selects 10-bit mode, bits 1 and 0 are never tried and read 0 on both `data_o` and `ser_o`. The frame still lasts 14 cycles.
- R10: `hold_o` is low in cycle 1 and when idle, and high in cycles 2 to 14. In cycle 2, `dac_code_o` is 0x800. While `done_o` is high, `dac_code_o` equals `data_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start-of-conversion level |
| chan_sel_i | input | 5 | Channel select |
| diff_mode_i | input | 1 | 1 = differential input mode |
| res_sel_i | input | 1 | 1 = 10-bit resolution, 0 = 12-bit |
| cmp_i | input | 1 | Comparator: input at or above DAC level |
| dac_code_o | output | 12 | DAC trial code |
| hold_o | output | 1 | Hold enable for the sample-and-hold |
| chan_o | output | 5 | Latched channel |
| diff_o | output | 1 | Latched input mode |
| done_o | output | 1 | End of conversion |
| data_o | output | 12 | Parallel result |
| ser_o | output | 1 | Serial result bit |

## Verification
The hardest cases to reach come from how the three control latches are timed against each other.

- **Resolution select while `done_o` is low.** A change here must have no effect. The bench sets 10-bit mode right after reset, before any frame has raised done, and expects a full 12-bit result.
- **Late mode change.** The bench flips `diff_mode_i` in the cycle just before the start edge and expects the earlier value on `diff_o`.
- **Back-to-back frames.** The bench holds start high across two frames and changes the analog value in the single done cycle between them. This shows that the second frame samples fresh input and that done drops at once.

// File: rtl/sar_conv_pkg.sv
package sar_conv_pkg;
  localparam int unsigned SAR_W_DEF = 12;
  localparam int unsigned LOW_W_DEF = 10;
  localparam int unsigned CH_W_DEF  = 5;

  typedef struct packed {
    logic launch;   // start accepted on this edge
    logic sample;   // frame cycle 1
    logic resolve;  // frame cycles 2..DATA_W+1
    logic last;     // final resolve cycle
  } frame_ph_t;
endpackage

// File: rtl/sar_frame_ctr.sv
module sar_frame_ctr
  import sar_conv_pkg::*;
#(
  parameter int unsigned DATA_W = SAR_W_DEF,
  parameter int unsigned IDX_W  = $clog2(DATA_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output frame_ph_t        ph_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             hold_o,
  output logic             done_o
);
  localparam int unsigned FRAME = DATA_W + 2;
  localparam int unsigned CNT_W = $clog2(FRAME + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q;
  logic             slot, launch;

  assign slot   = (cnt_q == '0) || (cnt_q == CNT_W'(FRAME));
  assign launch = start_i && slot;

  always_comb begin
    if (launch)    cnt_d = CNT_W'(1);
    else if (slot) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (launch)                           done_q <= 1'b0;
      else if (cnt_q == CNT_W'(FRAME - 1))  done_q <= 1'b1;
    end
  end

  always_comb begin
    ph_o.launch  = launch;
    ph_o.sample  = (cnt_q == CNT_W'(1));
    ph_o.resolve = (cnt_q >= CNT_W'(2)) && (cnt_q <= CNT_W'(FRAME - 1));
    ph_o.last    = (cnt_q == CNT_W'(FRAME - 1));
  end

  assign idx_o  = IDX_W'(CNT_W'(FRAME - 1) - cnt_q);
  assign hold_o = (cnt_q >= CNT_W'(2));
  assign done_o = done_q;

  assert_no_start_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !start_i) |=> (cnt_q == '0));
  assert_cnt_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && cnt_q != CNT_W'(FRAME)) |=> (cnt_q == $past(cnt_q) + 1'b1));
  assert_done_keep_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !start_i) |=> done_q);
  assert_done_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch |=> !done_q);
endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine
  import sar_conv_pkg::*;
#(
  parameter int unsigned DATA_W = SAR_W_DEF,
  parameter int unsigned LOW_W  = LOW_W_DEF,
  parameter int unsigned IDX_W  = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  frame_ph_t         ph_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              low_res_i,
  input  logic              cmp_i,
  output logic [DATA_W-1:0] dac_o,
  output logic [DATA_W-1:0] result_o,
  output logic              ser_o
);
  localparam logic [DATA_W-1:0] LOW_MASK = (DATA_W'(1) << (DATA_W - LOW_W)) - DATA_W'(1);

  logic [DATA_W-1:0] trial_q, trial_d, result_q, try_bit;
  logic              ser_q, bit_live, decided;

  assign try_bit  = DATA_W'(1) << idx_i;
  assign bit_live = !(low_res_i && LOW_MASK[idx_i]);
  assign decided  = bit_live && cmp_i;

  always_comb begin
    trial_d = trial_q;
    if (ph_i.launch)       trial_d = '0;
    else if (ph_i.resolve) trial_d[idx_i] = decided;
  end

  always_comb begin
    if (ph_i.sample)                    dac_o = '0;
    else if (ph_i.resolve && bit_live)  dac_o = trial_q | try_bit;
    else                                dac_o = trial_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trial_q  <= '0;
      result_q <= '0;
      ser_q    <= 1'b0;
    end else begin
      trial_q <= trial_d;
      if (ph_i.launch)       ser_q <= 1'b0;
      else if (ph_i.resolve) ser_q <= decided;
      if (ph_i.last)         result_q <= trial_d;
    end
  end

  assign result_o = result_q;
  assign ser_o    = ser_q;

  assert_low_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_i.last && low_res_i) |=> ((result_q & LOW_MASK) == '0));
  assert_ser_lsb_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_i.last |=> (result_q[0] == ser_q));
endmodule

// File: rtl/sar_ctl_latch.sv
module sar_ctl_latch
  import sar_conv_pkg::*;
#(
  parameter int unsigned CH_W = CH_W_DEF
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            launch_i,
  input  logic            done_i,
  input  logic [CH_W-1:0] chan_i,
  input  logic            diff_i,
  input  logic            res_i,
  output logic [CH_W-1:0] chan_o,
  output logic            diff_o,
  output logic            low_res_o
);
  logic [CH_W-1:0] chan_q;
  logic            diff_pre_q, diff_q, res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_q     <= '0;
      diff_pre_q <= 1'b0;
      diff_q     <= 1'b0;
      res_q      <= 1'b0;
    end else begin
      diff_pre_q <= diff_i;
      if (launch_i) begin
        chan_q <= chan_i;
        diff_q <= diff_pre_q;  // mode settled one cycle ahead of start
      end
      if (done_i) res_q <= res_i;
    end
  end

  assign chan_o    = chan_q;
  assign diff_o    = diff_q;
  assign low_res_o = res_q;

  assert_chan_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !launch_i |=> $stable(chan_q));
  assert_res_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(res_q));
  assert_diff_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !launch_i |=> $stable(diff_q));
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_conv_pkg::*;
#(
  parameter int unsigned DATA_W = SAR_W_DEF,
  parameter int unsigned LOW_W  = LOW_W_DEF,
  parameter int unsigned CH_W   = CH_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CH_W-1:0]   chan_sel_i,
  input  logic              diff_mode_i,
  input  logic              res_sel_i,
  input  logic              cmp_i,
  output logic [DATA_W-1:0] dac_code_o,
  output logic              hold_o,
  output logic [CH_W-1:0]   chan_o,
  output logic              diff_o,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              ser_o
);
  localparam int unsigned IDX_W = $clog2(DATA_W);

  frame_ph_t        ph;
  logic [IDX_W-1:0] idx;
  logic             low_res;

  sar_frame_ctr #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_frame (
    .clk_i, .rst_ni, .start_i,
    .ph_o(ph), .idx_o(idx), .hold_o, .done_o
  );

  sar_ctl_latch #(.CH_W(CH_W)) i_ctl (
    .clk_i, .rst_ni,
    .launch_i(ph.launch), .done_i(done_o),
    .chan_i(chan_sel_i), .diff_i(diff_mode_i), .res_i(res_sel_i),
    .chan_o, .diff_o, .low_res_o(low_res)
  );

  sar_bit_engine #(.DATA_W(DATA_W), .LOW_W(LOW_W), .IDX_W(IDX_W)) i_bits (
    .clk_i, .rst_ni, .ph_i(ph), .idx_i(idx), .low_res_i(low_res), .cmp_i,
    .dac_o(dac_code_o), .result_o(data_o), .ser_o
  );

  assert_dac_result_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (dac_code_o == data_o));
  assert_hold_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> hold_o);
endmodule

// File: tb/test_sar_conv_ctrl.sv
module test_sar_conv_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [4:0]  chan_sel_i = '0;
  logic        diff_mode_i = 1'b0;
  logic        res_sel_i = 1'b0;
  logic        cmp_i;
  logic [11:0] dac_code_o, data_o;
  logic        hold_o, diff_o, done_o, ser_o;
  logic [4:0]  chan_o;
  logic [11:0] vin_r = '0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  assign cmp_i = (vin_r >= dac_code_o);  // behavioural comparator

  sar_conv_ctrl i_sar_conv_ctrl (
    .clk_i(clk), .rst_ni, .start_i, .chan_sel_i, .diff_mode_i, .res_sel_i,
    .cmp_i, .dac_code_o, .hold_o, .chan_o, .diff_o, .done_o, .data_o, .ser_o
  );

  // {res, diff, chan, vin}
  localparam logic [18:0] VEC [6] = '{
    {1'b0, 1'b0, 5'd3,  12'hA5C},
    {1'b0, 1'b1, 5'd31, 12'hFFF},
    {1'b0, 1'b0, 5'd0,  12'h000},
    {1'b1, 1'b1, 5'd17, 12'h7FF},
    {1'b1, 1'b0, 5'd9,  12'h803},
    {1'b0, 1'b1, 5'd22, 12'h001}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one single conversion; low_exp selects the expected resolution
  task automatic conv(input logic [11:0] vin, input logic [4:0] ch, input logic df,
                      input logic rs, input logic low_exp, input logic flip_diff);
    logic [11:0] exp_v;
    exp_v = low_exp ? (vin & 12'hFFC) : vin;
    @(negedge clk);
    res_sel_i = rs; diff_mode_i = df; vin_r = vin;
    @(negedge clk);
    start_i = 1'b1; chan_sel_i = ch;
    if (flip_diff) diff_mode_i = ~df;
    @(negedge clk);  // cycle 1
    start_i = 1'b0;
    chk("R10 hold low in sample cycle", hold_o, 0);
    chk("R4 done falls at launch", done_o, 0);
    for (int k = 1; k <= 13; k++) begin
      @(negedge clk);  // cycle k+1
      if (k == 1) begin
        chan_sel_i = ~ch;
        chk("R10 first trial code", dac_code_o, 12'h800);
      end
      chk("R10 hold high", hold_o, 1);
      if (k >= 2) chk("R6 serial bit", ser_o, exp_v[13-k]);
      if (k < 13) chk("R3 done low mid frame", done_o, 0);
    end
    chk("R3 done in cycle 14", done_o, 1);
    chk(low_exp ? "R9 result" : "R5 result", data_o, exp_v);
    chk("R7 channel", chan_o, ch);
    chk("R8 mode", diff_o, df);
    chk("R10 dac equals result", dac_code_o, exp_v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R4 reset done", done_o, 0);
    chk("R4 reset hold", hold_o, 0);
    chk("R4 reset data", data_o, 0);
    chk("R4 reset ser", ser_o, 0);
    rst_ni = 1'b1;

    // R9: resolution change while done low is ignored
    conv(12'h3A7, 5'd5, 1'b0, 1'b1, 1'b0, 1'b0);

    foreach (VEC[i])
      conv(VEC[i][11:0], VEC[i][16:12], VEC[i][17], VEC[i][18], VEC[i][18], 1'b0);

    // R8: late mode change ignored
    conv(12'h5A5, 5'd12, 1'b1, 1'b0, 1'b0, 1'b1);

    // R1: no start keeps block idle
    vin_r = 12'h111;
    repeat (20) @(negedge clk);
    chk("R1 done kept", done_o, 1);
    chk("R1 data kept", data_o, 12'h5A5);
    chk("R1 idle hold", hold_o, 0);

    // R2: back-to-back frames
    @(negedge clk);
    vin_r = 12'h9C3; start_i = 1'b1;
    @(negedge clk);
    for (int k = 1; k <= 13; k++) @(negedge clk);
    chk("R2 first done", done_o, 1);
    chk("R2 first data", data_o, 12'h9C3);
    vin_r = 12'h2B6;
    @(negedge clk);
    start_i = 1'b0;
    chk("R2 done single cycle", done_o, 0);
    chk("R2 new sample cycle", hold_o, 0);
    for (int k = 1; k <= 13; k++) @(negedge clk);
    chk("R2 second done", done_o, 1);
    chk("R2 second data", data_o, 12'h2B6);

    // R4: reset during a frame
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R4 mid-frame reset done", done_o, 0);
    chk("R4 mid-frame reset hold", hold_o, 0);
    chk("R4 mid-frame reset data", data_o, 0);
    rst_ni = 1'b1;
    repeat (16) @(negedge clk);
    chk("R1 idle after reset", done_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule